// File: doc/BRIEF.md
# UART Receive Character Queue with Line Status

This unit sits between a UART's receive shift register and the bus-side read logic. Each time the shift register finishes a character, it offers that character with a one-bit parity-error tag. The unit queues the tagged characters in a first-in first-out store, 16 entries deep by default, and shows the oldest unread character on its data output. A data-register read strobe removes that oldest character.

The unit also drives three bits of a read-only line status word:
- **Data-ready** is high while any unread character is held.
- **Overrun** records that a finished character arrived while the store was full. That character is thrown away and the stored characters are left as they were.
- **Parity error** records that a character whose tag is set has become the oldest entry.

Both error bits are sticky. A status-register read strobe clears them.

Top module: `rxq_line_status`

## Requirements
- R1: After reset the status word `stat_o` is 3'b000 and the queue holds no characters.
- R2: `stat_o[0]` (data-ready) is 1 exactly when the queue holds at least one unread character; it follows the clock edge that stores the first character or removes the last one.
- R3: Characters leave in arrival order. `head_data_o` shows the oldest unread character. A cycle with `data_rd_i` high removes it at the clock edge. The queue holds up to DEPTH (default 16) characters.
- R4: A data read while the queue is empty has no effect: the status word is unchanged and a later character becomes the head normally.
- R5: A character offered while DEPTH characters are held is discarded. The stored characters and their order are unchanged. This applies even when a data read occurs in the same cycle: that read still removes the head.
- R6: `stat_o[1]` (overrun) becomes 1 at the clock edge of the overrun cycle. It returns to 0 at the edge of a cycle with `stat_rd_i` high.
- R7: If an overrun and a status read happen in the same cycle, `stat_o[1]` stays 1.
- R8: `stat_o[2]` (parity error) becomes 1 at the clock edge at which a character with its tag set becomes the head. This happens either when it enters an empty queue or when the entry ahead of it is read out. The bit stays 1 until a status read, even after that character is removed.
- R9: A status read clears `stat_o[2]` at its clock edge. If a tagged character becomes the head in the same cycle, the bit stays 1.
- R10: Characters whose tag is clear never set `stat_o[2]`. A tagged character that is not yet at the head does not set it either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chr_valid_i | input | 1 | One-cycle strobe: a character has finished assembly |
| chr_data_i | input | 8 | Assembled character |
| chr_perr_i | input | 1 | Parity-error tag of that character |
| data_rd_i | input | 1 | Data-register read strobe; removes the head character |
| stat_rd_i | input | 1 | Status-register read strobe; clears the error bits |
| head_data_o | output | 8 | Oldest unread character (valid when `stat_o[0]` is 1) |
| stat_o | output | 3 | Line status: bit 0 data-ready, bit 1 overrun, bit 2 parity error |

## Verification
**Single and interleaved traffic.** A table of single-cycle operations runs clean and tagged characters through the queue one at a time. It also mixes in simultaneous write-and-read cycles at depth one. This separates a parity flag raised when a tagged character reaches the head from one raised when it merely enters the queue.

**Filled queue and overrun.** A full fill with distinct values is followed by a drain. Extra characters offered at full, including one offered together with a data read, show that dropped characters never appear and that the order is kept.

**Same-cycle collisions and empty reads.** Status reads are made in the same cycle as an overrun and as a tagged character arriving at the head; these show the set-over-clear priority. Reads on an empty queue, and a reset in mid-run, close the set.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int unsigned CHR_W  = 8;
  localparam int unsigned STAT_W = 3;

  // Status word bit positions (decoded by the register read path)
  localparam int unsigned ST_READY = 0;
  localparam int unsigned ST_OVRUN = 1;
  localparam int unsigned ST_PERR  = 2;

  typedef struct packed {
    logic             perr;
    logic [CHR_W-1:0] data;
  } rxq_entry_t;

endpackage

// File: rtl/rxq_rst_sync.sv
module rxq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push_req_i,
  input  rxq_entry_t push_ent_i,
  input  logic       pop_req_i,
  output rxq_entry_t head_o,
  output logic       nonempty_o,
  output logic       ovrun_evt_o,
  output logic       head_adv_o,
  output logic       head_perr_nxt_o
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  rxq_entry_t       mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [PTR_W-1:0] rd_ptr_inc;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  logic is_full, is_empty;
  logic do_push, do_pop;

  always_comb begin
    is_full    = (cnt_q == CNT_FULL);
    is_empty   = (cnt_q == '0);
    do_pop     = pop_req_i && !is_empty;
    do_push    = push_req_i && !is_full;
    rd_ptr_inc = (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + PTR_W'(1);

    wr_ptr_d = wr_ptr_q;
    if (do_push) begin
      wr_ptr_d = (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + PTR_W'(1);
    end

    rd_ptr_d = do_pop ? rd_ptr_inc : rd_ptr_q;

    cnt_d = cnt_q;
    if (do_push && !do_pop) begin
      cnt_d = cnt_q + CNT_ONE;
    end else if (do_pop && !do_push) begin
      cnt_d = cnt_q - CNT_ONE;
    end
  end

  // A new entry reaches the head when it lands in an empty queue,
  // replaces the sole entry being read out, or follows a popped head.
  always_comb begin
    head_adv_o      = 1'b0;
    head_perr_nxt_o = 1'b0;
    if (do_pop && (cnt_q > CNT_ONE)) begin
      head_adv_o      = 1'b1;
      head_perr_nxt_o = mem_q[rd_ptr_inc].perr;
    end else if (do_push && (is_empty || (do_pop && cnt_q == CNT_ONE))) begin
      head_adv_o      = 1'b1;
      head_perr_nxt_o = push_ent_i.perr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // Storage array: written only on accepted pushes, no reset needed
  always_ff @(posedge clk) begin
    if (do_push) begin
      mem_q[wr_ptr_q] <= push_ent_i;
    end
  end

  assign head_o      = mem_q[rd_ptr_q];
  assign nonempty_o  = !is_empty;
  assign ovrun_evt_o = push_req_i && is_full;

  // R3: occupancy never passes the capacity
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);

  // R5: an overrun without a read leaves the stored occupancy unchanged
  a_r5_keep_on_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req_i && is_full && !pop_req_i) |=> (cnt_q == CNT_FULL));

  // R4: a read on an empty queue with no write leaves it empty
  a_r4_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req_i && is_empty && !push_req_i) |=> (cnt_q == '0));

endmodule

// File: rtl/rxq_status.sv
module rxq_status
  import rxq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nonempty_i,
  input  logic              ovrun_evt_i,
  input  logic              head_adv_i,
  input  logic              head_perr_nxt_i,
  input  logic              stat_rd_i,
  output logic [STAT_W-1:0] stat_o
);

  logic ovr_q, ovr_d;
  logic pe_q, pe_d;
  logic pe_set;

  always_comb begin
    pe_set = head_adv_i && head_perr_nxt_i;
    // set has priority over the read-clear
    ovr_d  = ovrun_evt_i || (ovr_q && !stat_rd_i);
    pe_d   = pe_set || (pe_q && !stat_rd_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      pe_q  <= 1'b0;
    end else begin
      ovr_q <= ovr_d;
      pe_q  <= pe_d;
    end
  end

  always_comb begin
    stat_o           = '0;
    stat_o[ST_READY] = nonempty_i;
    stat_o[ST_OVRUN] = ovr_q;
    stat_o[ST_PERR]  = pe_q;
  end

  // R6: overrun event is visible after its clock edge
  a_r6_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
    ovrun_evt_i |=> ovr_q);

  // R6/R7: a status read without a new overrun clears the flag
  a_r6_ovr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_i && !ovrun_evt_i) |=> !ovr_q);

  // R8: tagged character reaching the head raises the parity flag
  a_r8_pe_set: assert property (@(posedge clk) disable iff (!rst_n)
    (head_adv_i && head_perr_nxt_i) |=> pe_q);

  // R9: a status read without a new tagged head clears the parity flag
  a_r9_pe_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_i && !(head_adv_i && head_perr_nxt_i)) |=> !pe_q);

  // R10: the parity flag never rises without a tagged head arrival
  a_r10_pe_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!pe_q && !(head_adv_i && head_perr_nxt_i)) |=> !pe_q);

endmodule

// File: rtl/rxq_line_status.sv
module rxq_line_status
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chr_valid_i,
  input  logic [CHR_W-1:0]  chr_data_i,
  input  logic              chr_perr_i,
  input  logic              data_rd_i,
  input  logic              stat_rd_i,
  output logic [CHR_W-1:0]  head_data_o,
  output logic [STAT_W-1:0] stat_o
);

  logic       srst_n;
  rxq_entry_t push_ent;
  rxq_entry_t head_ent;
  logic       nonempty;
  logic       ovrun_evt;
  logic       head_adv;
  logic       head_perr_nxt;

  rxq_rst_sync #(
    .STAGES (2)
  ) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  always_comb begin
    push_ent.perr = chr_perr_i;
    push_ent.data = chr_data_i;
  end

  rxq_store #(
    .DEPTH (DEPTH)
  ) u_store (
    .clk             (clk),
    .rst_n           (srst_n),
    .push_req_i      (chr_valid_i),
    .push_ent_i      (push_ent),
    .pop_req_i       (data_rd_i),
    .head_o          (head_ent),
    .nonempty_o      (nonempty),
    .ovrun_evt_o     (ovrun_evt),
    .head_adv_o      (head_adv),
    .head_perr_nxt_o (head_perr_nxt)
  );

  rxq_status u_status (
    .clk             (clk),
    .rst_n           (srst_n),
    .nonempty_i      (nonempty),
    .ovrun_evt_i     (ovrun_evt),
    .head_adv_i      (head_adv),
    .head_perr_nxt_i (head_perr_nxt),
    .stat_rd_i       (stat_rd_i),
    .stat_o          (stat_o)
  );

  assign head_data_o = head_ent.data;

  // R2: data-ready drops only after the queue is read out or reset
  a_r2_ready_hold: assert property (@(posedge clk) disable iff (!srst_n)
    (stat_o[ST_READY] && !data_rd_i) |=> stat_o[ST_READY]);

endmodule

// File: tb/rxq_line_status_tb.sv
module rxq_line_status_tb;

  logic       clk;
  logic       rst_n;
  logic       chr_valid_i;
  logic [7:0] chr_data_i;
  logic       chr_perr_i;
  logic       data_rd_i;
  logic       stat_rd_i;
  logic [7:0] head_data_o;
  logic [2:0] stat_o;

  int n_checks = 0;
  int n_errors = 0;

  rxq_line_status #(.DEPTH(16)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .chr_valid_i (chr_valid_i),
    .chr_data_i  (chr_data_i),
    .chr_perr_i  (chr_perr_i),
    .data_rd_i   (data_rd_i),
    .stat_rd_i   (stat_rd_i),
    .head_data_o (head_data_o),
    .stat_o      (stat_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Vector layout: {valid, data[7:0], perr, drd, srd, exp_stat[2:0], hchk, exp_head[7:0]}
  localparam int NVEC = 11;
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, 3'b001, 1'b1, 8'hA5}, // R2 first char
    {1'b1, 8'h3C, 1'b1, 1'b0, 1'b0, 3'b001, 1'b1, 8'hA5}, // R10 tag not at head
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 3'b101, 1'b1, 8'h3C}, // R8 tag reaches head
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 3'b001, 1'b1, 8'h3C}, // R9 status read clears
    {1'b1, 8'h77, 1'b0, 1'b1, 1'b0, 3'b001, 1'b1, 8'h77}, // R3 write+read at depth 1
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 3'b000, 1'b0, 8'h00}, // R2 empty again
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 3'b000, 1'b0, 8'h00}, // R4 read on empty
    {1'b1, 8'h11, 1'b1, 1'b0, 1'b0, 3'b101, 1'b1, 8'h11}, // R8 tagged into empty
    {1'b1, 8'h22, 1'b0, 1'b0, 1'b1, 3'b001, 1'b1, 8'h11}, // R9 clear, R3 head kept
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 3'b001, 1'b1, 8'h22}, // R10 clean head
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 3'b000, 1'b0, 8'h00}  // R2 drained
  };

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // One operation cycle: inputs change 2 ns after a rising edge
  task automatic step(input logic v, input logic [7:0] d, input logic p,
                      input logic rd, input logic sr);
    chr_valid_i = v;
    chr_data_i  = d;
    chr_perr_i  = p;
    data_rd_i   = rd;
    stat_rd_i   = sr;
    @(posedge clk);
    #2;
    chr_valid_i = 1'b0;
    chr_perr_i  = 1'b0;
    data_rd_i   = 1'b0;
    stat_rd_i   = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    chr_valid_i = 1'b0;
    chr_data_i  = 8'h00;
    chr_perr_i  = 1'b0;
    data_rd_i   = 1'b0;
    stat_rd_i   = 1'b0;
    do_reset();
    check("R1 reset status", {6'd0, stat_o}, 9'h000);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][23], VEC[i][22:15], VEC[i][14], VEC[i][13], VEC[i][12]);
      check($sformatf("R2/R8/R9 table status %0d", i), {6'd0, stat_o}, {6'd0, VEC[i][11:9]});
      if (VEC[i][8]) begin
        check($sformatf("R3 table head %0d", i), {1'b0, head_data_o}, {1'b0, VEC[i][7:0]});
      end
    end

    // Fill to capacity
    for (int i = 0; i < 16; i++) begin
      step(1'b1, 8'h40 + 8'(i), 1'b0, 1'b0, 1'b0);
    end
    check("R3 full no overrun", {6'd0, stat_o}, 9'h001);
    step(1'b1, 8'hEE, 1'b0, 1'b0, 1'b0);
    check("R6 overrun sets", {6'd0, stat_o}, 9'h003);
    check("R5 head kept", {1'b0, head_data_o}, 9'h040);
    step(1'b1, 8'hEF, 1'b0, 1'b0, 1'b1);
    check("R7 overrun with status read", {6'd0, stat_o}, 9'h003);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    check("R6 overrun clears", {6'd0, stat_o}, 9'h001);
    step(1'b1, 8'hF0, 1'b0, 1'b1, 1'b0);
    check("R5 overrun with read", {6'd0, stat_o}, 9'h003);
    check("R5 read still pops", {1'b0, head_data_o}, 9'h041);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    step(1'b1, 8'h50, 1'b0, 1'b0, 1'b0);
    check("R5 room after read", {6'd0, stat_o}, 9'h001);
    for (int i = 1; i < 16; i++) begin
      check($sformatf("R3/R5 drain order %0d", i), {1'b0, head_data_o}, {1'b0, 8'h40 + 8'(i)});
      step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    end
    check("R5 last accepted", {1'b0, head_data_o}, 9'h050);
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    check("R2 empty after drain", {6'd0, stat_o}, 9'h000);

    // Parity set and status read in same cycle
    step(1'b1, 8'h99, 1'b1, 1'b0, 1'b1);
    check("R9 set wins over read", {6'd0, stat_o}, 9'h005);
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    check("R8 flag sticky after pop", {6'd0, stat_o}, 9'h004);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    check("R9 cleared", {6'd0, stat_o}, 9'h000);

    // Empty reads then a normal write
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    check("R4 empty reads", {6'd0, stat_o}, 9'h000);
    step(1'b1, 8'h5A, 1'b0, 1'b0, 1'b0);
    check("R4 head after empty reads", {1'b0, head_data_o}, 9'h05A);

    // Reset mid-run with data and flags present
    step(1'b1, 8'h6B, 1'b1, 1'b0, 1'b0);
    step(1'b1, 8'h6C, 1'b0, 1'b1, 1'b0);
    check("R8 before reset", {6'd0, stat_o}, 9'h005);
    do_reset();
    check("R1 reset mid-run", {6'd0, stat_o}, 9'h000);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule